// File: doc/BRIEF.md
# Serial Register Access Bridge

This block lets an external host reach a 32-bit internal register bus over a four-wire serial link. The link runs in clock mode 0, so data is sampled on the rising edge of the serial clock and changed on the falling edge. Every frame opens with a 24-bit header. The header's first bit selects the direction and the remaining 23 bits give a word address, which is the byte address divided by four. A write frame then carries 32 payload bits. A read frame first carries a programmable number of padding bytes and then returns 32 payload bits on the slave output. The padding gives a slow internal access time to finish before the first data bit has to be driven.

The bridge holds three local words at the bottom of its address space. The order word selects the payload byte order and bit order. The config/status word holds the padding count, a sticky flag raised when the padding was too short, and a fixed interface identity code. The reset word carries a self-clearing bit that returns the local configuration to its defaults. Every other address becomes a valid/ready request on the internal bus. The serial pins are brought into the system clock through a two-flop synchronizer, so the system clock must run at least four times faster than the serial clock.

Top module: `spi_reg_bridge`

## Requirements
- R1: The header is 24 bits and is sent most significant bit first in every payload order. Its first bit is 1 for a write and 0 for a read, and its other 23 bits are the word address.
- R2: Payload order field order[1:0]: bit 0 set means the most significant byte goes first, and bit 1 set means each byte is sent least significant bit first. The codes are 00 = little-endian MSB-first, 01 = big-endian MSB-first, 10 = little-endian LSB-first and 11 = big-endian LSB-first. Written data reaches the bus with its bits in place, and read data returns the same way.
- R3: A write is committed only after all 32 payload bits have arrived. If chip select rises before then, the frame is dropped with no bus access and no local register change.
- R4: A read of a non-local address issues one bus read when the last header bit arrives. The word returned by the bus is sent on MISO after the padding bytes, with the first data bit valid before the first data rising edge.
- R5: Local word 1 bits [3:0] hold the padding byte count. The count is written by a frame and read back, and it sets how many bytes are skipped before read data begins.
- R6: Local word 1 bit 16 is a sticky flag. It is set when the first read data bit is due and the bus response has not yet arrived. It stays set until a reset.
- R7: Local word 1 bits [31:24] read back the interface code 0x02, and its other unused bits read 0.
- R8: Local word 0 takes the order code from its bits [1:0] and reads back as four identical mirrored bytes, so the code 01 reads as 0x81818181. Writing 0x81818181 selects code 01 whatever the current order is.
- R9: Writing 1 to bit 0 of local word 2 performs a self-clearing soft reset. The reset clears the order code to 00, the padding count to 0 and the sticky flag. Word 2 reads back 0.
- R10: A bus request stays asserted, with its address, direction and write data held stable, until ready is seen. Each write frame to a non-local address causes exactly one bus write.
- R11: After reset, MISO is low, no bus request is pending, the order code is 00, the padding count is 0 and the flag is clear.
- R12: While chip select is high, MISO is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| bus_req_o | output | 1 | Internal bus request valid |
| bus_we_o | output | 1 | Request is a write |
| bus_addr_o | output | 23 | Internal word address |
| bus_wdata_o | output | 32 | Internal write data |
| bus_ready_i | input | 1 | Request accepted; read data valid |
| bus_rdata_i | input | 32 | Internal read data |

## Verification
Each serial edge acts inside the design about three system cycles after the pin changes: two cycles in the synchronizer and one in the edge detector. The bench therefore drives and samples only on falling system-clock edges, holding each serial level for five system cycles. It samples MISO at the end of the low phase, a full half serial period after the falling edge that changed it. A bus request rises one cycle after the final header or payload bit is processed. Every frame is followed by twenty idle cycles, so the responder write or the local register update has completed before the bench looks at memory or status.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;
  localparam int ADDR_W   = 23;
  localparam int DATA_W   = 32;
  localparam int HDR_BITS = ADDR_W + 1;

  typedef logic [1:0] order_t;

  // bit index within the data word for serial position i
  function automatic int unsigned wire_pos(order_t o, int unsigned i);
    int unsigned k, j;
    k = i / 8;
    j = i % 8;
    return ((o[0] ? 3 - k : k) * 8) + (o[1] ? j : 7 - j);
  endfunction

  // data word -> serial stream, stream bit 0 at index 31
  function automatic logic [DATA_W-1:0] to_wire(order_t o, logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] s;
    for (int unsigned i = 0; i < DATA_W; i++) s[DATA_W-1-i] = w[wire_pos(o, i)];
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] from_wire(order_t o, logic [DATA_W-1:0] s);
    logic [DATA_W-1:0] w;
    for (int unsigned i = 0; i < DATA_W; i++) w[wire_pos(o, i)] = s[DATA_W-1-i];
    return w;
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/spi_bridge_cfg.sv
module spi_bridge_cfg
  import spi_bridge_pkg::*;
#(
  parameter int          PAD_W   = 4,
  parameter logic [7:0]  IF_CODE = 8'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_idx_i,
  input  logic [PAD_W-1:0]  wr_low_i,
  input  logic [1:0]        rd_idx_i,
  input  logic              set_err_i,
  output order_t            order_o,
  output logic [PAD_W-1:0]  pad_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic   srst_q;
  logic   err_q;
  order_t order_q;
  logic [PAD_W-1:0] pad_q;
  logic [7:0] mirror_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q  <= 1'b0;
      err_q   <= 1'b0;
      order_q <= '0;
      pad_q   <= '0;
    end else if (srst_q) begin
      srst_q  <= 1'b0;
      err_q   <= 1'b0;
      order_q <= '0;
      pad_q   <= '0;
    end else begin
      if (set_err_i) err_q <= 1'b1;
      if (wr_en_i) begin
        case (wr_idx_i)
          2'd0:    order_q <= wr_low_i[1:0];
          2'd1:    pad_q   <= wr_low_i;
          2'd2:    srst_q  <= wr_low_i[0];
          default: ;
        endcase
      end
    end
  end

  assign mirror_byte = {order_q[0], order_q[1], 4'b0000, order_q[1], order_q[0]};

  always_comb begin
    case (rd_idx_i)
      2'd0:    rd_data_o = {4{mirror_byte}};
      2'd1:    rd_data_o = {IF_CODE, 7'd0, err_q, 16'(pad_q)};
      default: rd_data_o = '0;
    endcase
  end

  assign order_o = order_q;
  assign pad_o   = pad_q;

  a_r9_soft_reset_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> (order_q == 2'b00) && (pad_q == '0) && !err_q && !srst_q);

  a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !srst_q) |=> err_q);

  a_r6_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(set_err_i));
endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
  import spi_bridge_pkg::*;
#(
  parameter int               PAD_W    = 4,
  parameter logic [7:0]       IF_CODE  = 8'h02,
  parameter logic [ADDR_W-1:0] CFG_BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ready_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  localparam int MAX_BITS = HDR_BITS + 8 * ((1 << PAD_W) - 1) + DATA_W;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);
  localparam int N_LOCAL  = 3;

  function automatic logic is_local(logic [ADDR_W-1:0] a);
    return (a >= CFG_BASE) && (a < CFG_BASE + ADDR_W'(N_LOCAL));
  endfunction

  logic cs_s, sclk_s, mosi_s, sclk_q;
  logic rise, fall;

  spi_in_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, mosi_i}),
    .q_o   ({cs_s, sclk_s, mosi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_s;
  end

  assign rise = !cs_s && sclk_s && !sclk_q;
  assign fall = !cs_s && !sclk_s && sclk_q;

  // frame state
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-2:0] sh_in;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] tx_sh;

  order_t            order;
  logic [PAD_W-1:0]  pad;
  logic [DATA_W-1:0] cfg_rdata;
  logic [CNT_W-1:0]  data_start;

  logic              addr_done, launch_rd, commit_wr, set_err, rsp_rd;
  logic [ADDR_W-1:0] new_addr;
  logic              new_we;
  logic [DATA_W-1:0] wdata_new;

  assign data_start = CNT_W'(HDR_BITS) + CNT_W'({pad, 3'b000});
  assign new_addr   = {sh_in[ADDR_W-2:0], mosi_s};
  assign new_we     = sh_in[ADDR_W-1];
  assign addr_done  = rise && (bit_cnt == CNT_W'(HDR_BITS - 1));
  assign launch_rd  = addr_done && !new_we;
  assign commit_wr  = rise && we_q && (bit_cnt == CNT_W'(HDR_BITS + DATA_W - 1));
  assign wdata_new  = from_wire(order, {sh_in, mosi_s});
  assign set_err    = fall && !we_q && (bit_cnt == data_start) && !rd_valid;
  assign rsp_rd     = bus_req_o && bus_ready_i && !bus_we_o;

  spi_bridge_cfg #(.PAD_W(PAD_W), .IF_CODE(IF_CODE)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (commit_wr && is_local(addr_q)),
    .wr_idx_i (2'(addr_q - CFG_BASE)),
    .wr_low_i (wdata_new[PAD_W-1:0]),
    .rd_idx_i (2'(new_addr - CFG_BASE)),
    .set_err_i(set_err),
    .order_o  (order),
    .pad_o    (pad),
    .rd_data_o(cfg_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt  <= '0;
      sh_in    <= '0;
      addr_q   <= '0;
      we_q     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      tx_sh    <= '0;
    end else if (cs_s) begin
      bit_cnt  <= '0;
      we_q     <= 1'b0;
      rd_valid <= 1'b0;
      tx_sh    <= '0;
    end else begin
      if (rise) begin
        sh_in   <= {sh_in[DATA_W-3:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (addr_done) begin
        addr_q <= new_addr;
        we_q   <= new_we;
      end
      if (launch_rd && is_local(new_addr)) begin
        rd_valid <= 1'b1;
        rd_data  <= cfg_rdata;
      end
      if (rsp_rd) begin
        rd_valid <= 1'b1;
        rd_data  <= bus_rdata_i;
      end
      if (fall && !we_q) begin
        if (bit_cnt == data_start)
          tx_sh <= rd_valid ? to_wire(order, rd_data) : '0;
        else if (bit_cnt > data_start)
          tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign miso_o = tx_sh[DATA_W-1];

  // internal bus master
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_req_o   <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
    end else begin
      if (bus_req_o && bus_ready_i) bus_req_o <= 1'b0;
      if (launch_rd && !is_local(new_addr)) begin
        bus_req_o  <= 1'b1;
        bus_we_o   <= 1'b0;
        bus_addr_o <= new_addr;
      end
      if (commit_wr && !is_local(addr_q)) begin
        bus_req_o   <= 1'b1;
        bus_we_o    <= 1'b1;
        bus_addr_o  <= addr_q;
        bus_wdata_o <= wdata_new;
      end
    end
  end

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ready_i) |=> bus_req_o && $stable(bus_addr_o)
                                    && $stable(bus_we_o) && $stable(bus_wdata_o));

  a_r3_write_after_payload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bus_req_o) && bus_we_o) |-> ($past(bit_cnt) == CNT_W'(HDR_BITS + DATA_W - 1)));

  a_r4_read_after_header: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bus_req_o) && !bus_we_o) |-> ($past(bit_cnt) == CNT_W'(HDR_BITS - 1)));

  a_r12_miso_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !miso_o);
endmodule

// File: tb/spi_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module spi_reg_bridge_tb_top;
  localparam int HALF = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, bus_req, bus_we, bus_ready;
  logic [22:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #5 clk = ~clk;

  spi_reg_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_ready_i(bus_ready), .bus_rdata_i(bus_rdata)
  );

  // responder: ready after lat waiting cycles
  logic [31:0] mem [16];
  int lat = 1;
  int wait_cnt = 0;
  int wr_cnt = 0;
  assign bus_ready = bus_req && (wait_cnt >= lat);
  assign bus_rdata = mem[bus_addr[3:0]];
  always_ff @(posedge clk) begin
    wait_cnt <= (bus_req && !bus_ready) ? wait_cnt + 1 : 0;
    if (bus_req && bus_ready && bus_we) begin
      mem[bus_addr[3:0]] <= bus_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  int n_chk = 0, n_err = 0;
  logic [1:0] cur_order = 2'b00;
  int cur_pad = 0;
  logic done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int tb_pos(logic [1:0] o, int i);
    int byte_n = o[0] ? 3 - i / 8 : i / 8;
    int bit_n  = o[1] ? i % 8 : 7 - i % 8;
    return byte_n * 8 + bit_n;
  endfunction

  task automatic spi_bit(input logic b, output logic r);
    mosi = b;
    #(HALF);
    r = miso;
    sclk = 1'b1;
    #(HALF);
    sclk = 1'b0;
  endtask

  task automatic spi_frame(input logic we, input logic [22:0] a, input logic [31:0] wd,
                           input int stop_at, output logic [31:0] rd);
    logic [23:0] hdr;
    logic r, b;
    int total, dstart;
    hdr = {we, a};
    rd = '0;
    dstart = 24 + cur_pad * 8;
    total = we ? 56 : dstart + 32;
    @(negedge clk);
    cs_n = 1'b0;
    #(HALF);
    for (int n = 0; n < total; n++) begin
      if (stop_at > 0 && n >= stop_at) break;
      if (n < 24)      b = hdr[23-n];
      else if (we)     b = wd[tb_pos(cur_order, n - 24)];
      else             b = 1'b0;
      spi_bit(b, r);
      if (!we && n >= dstart) rd[tb_pos(cur_order, n - dstart)] = r;
    end
    cs_n = 1'b1;
    mosi = 1'b0;
    #(HALF);
    repeat (20) @(negedge clk);
  endtask

  task automatic wr(input logic [22:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    spi_frame(1'b1, a, d, 0, dummy);
  endtask

  task automatic rd(input logic [22:0] a, output logic [31:0] d);
    spi_frame(1'b0, a, '0, 0, d);
  endtask

  task automatic set_order(input logic [1:0] o);
    logic [7:0] by;
    by = {o[0], o[1], 4'b0000, o[1], o[0]};
    wr(23'd0, {4{by}});
    cur_order = o;
  endtask

  task automatic set_pad(input int p);
    wr(23'd1, 32'(p));
    cur_pad = p;
  endtask

  // {order[1:0], pad[3:0], addr[22:0], data[31:0]}
  localparam logic [60:0] VEC [6] = '{
    {2'b00, 4'd0, 23'h000010, 32'h1234_5678},
    {2'b01, 4'd0, 23'h000011, 32'hCAFE_F00D},
    {2'b10, 4'd1, 23'h000012, 32'h8000_0001},
    {2'b11, 4'd2, 23'h000013, 32'h0F1E_2D3C},
    {2'b01, 4'd3, 23'h00001F, 32'hFFFF_0000},
    {2'b00, 4'd0, 23'h000014, 32'hA5A5_5A5A}
  };

  initial begin
    logic [31:0] got;
    int wc;
    for (int i = 0; i < 16; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
    repeat (3) @(negedge clk);
    chk("R11 miso", {31'd0, miso}, 32'd0);
    chk("R11 req", {31'd0, bus_req}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(23'd1, got); chk("R7 R11 cfgstat", got, 32'h0200_0000);
    rd(23'd0, got); chk("R11 order", got, 32'h0000_0000);
    chk("R12 miso idle", {31'd0, miso}, 32'd0);

    // vector walk: R1 R2 R4 R5 R10
    foreach (VEC[v]) begin
      set_order(VEC[v][60:59]);
      set_pad(int'(VEC[v][58:55]));
      wc = wr_cnt;
      wr(VEC[v][54:32], VEC[v][31:0]);
      chk("R2 R10 bus write", mem[VEC[v][35:32]], VEC[v][31:0]);
      chk("R10 one write", 32'(wr_cnt - wc), 32'd1);
      rd(VEC[v][54:32], got);
      chk("R4 R5 read", got, VEC[v][31:0]);
    end

    // R8: write mirrored code from LSB-first big-endian
    set_order(2'b11);
    wr(23'd0, 32'h8181_8181);
    cur_order = 2'b01;
    rd(23'd0, got); chk("R8 mirrored", got, 32'h8181_8181);

    // R3: abort after 40 bits
    wc = wr_cnt;
    spi_frame(1'b1, 23'h15, 32'h1111_2222, 40, got);
    chk("R3 no bus write", 32'(wr_cnt - wc), 32'd0);
    rd(23'h15, got); chk("R3 mem intact", got, 32'hDEAD_0005);
    spi_frame(1'b1, 23'd1, 32'h0000_0007, 50, got);
    rd(23'd1, got); chk("R3 local intact", got, 32'h0200_0000);

    // R6: padding too short
    set_pad(0);
    lat = 10;
    rd(23'h10, got);
    rd(23'd1, got); chk("R6 flag set", got, 32'h0201_0000);
    set_pad(1);
    rd(23'h11, got); chk("R5 pad hides latency", got, 32'hCAFE_F00D);
    rd(23'd1, got); chk("R6 sticky", got, 32'h0201_0001);
    lat = 1;

    // R9: soft reset
    wr(23'd2, 32'h0101_0101);
    cur_order = 2'b00;
    cur_pad = 0;
    rd(23'd1, got); chk("R9 cfgstat", got, 32'h0200_0000);
    rd(23'd0, got); chk("R9 order", got, 32'h0000_0000);
    rd(23'd2, got); chk("R9 reads zero", got, 32'h0000_0000);
    chk("R12 miso idle end", {31'd0, miso}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(150_000 * 10);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule